// File: doc/BRIEF.md
# Motion Sensor Interrupt Enable, Routing and Latch Unit

This unit sits between the event detectors of a motion sensor core and two interrupt pins. Eight event inputs arrive from the core. Five of them are one-cycle pulses: single tap, double tap, activity, inactivity and free fall. These are captured into a status register and held there. Three of them are live conditions: data ready, buffer watermark and buffer overrun. For these the status bit simply tracks the condition, so it clears by itself once the host has drained the data that caused it.

A per-event enable register gates which status bits reach a pin. A per-event steering register sends each enabled bit to pin 1 or to pin 2. Each pin is the active-high OR of everything steered to it. The host reaches the three registers through a small synchronous read/write port. Reading the status register returns its contents and clears the held (pulse) bits.

Top module: `sns_irq_ctrl`

## Requirements
- R1: After reset the enable, steering and status registers read 0x00, `bus_rdata` is 0x00 and both pins are low.
- R2: Status bit order, MSB first, is: data ready (7), single tap (6), double tap (5), activity (4), inactivity (3), free fall (2), watermark (1), overrun (0). A pulse on a held bit (6..2) sets that bit one clock later, and the bit remains set after the pulse ends.
- R3: Register select is `bus_addr`: 0 = enable, 1 = steering, 2 = status, 3 = unused. A read returns the selected value on `bus_rdata` one clock after the strobe. A status read returns the pre-clear value and clears bits 6..2 on the same edge, while bits 7, 1 and 0 are left unchanged.
- R4: Bits 7, 1 and 0 equal their event input as sampled on the previous clock. They drop when the input drops, whether or not the status register is read.
- R5: If a held event pulse arrives in the same cycle as a status read, the bit stays set after that read.
- R6: Pin 1 is high when any status bit is set, enabled, and has its steering bit at 0. Pin 2 is the same for steering bit 1.
- R7: With the enable register at 0x00 both pins are low, yet status bits still set and can be polled.
- R8: Enable and steering registers read back exactly what was written. Writes to address 2 or 3 change no register, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | Event pulses (bits 6..2) and live conditions (bits 7,1,0) |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_pin1 | output | 1 | Interrupt pin 1, active high |
| irq_pin2 | output | 1 | Interrupt pin 2, active high |

## Verification
A wrong status, enable or steering bit reaches the pins in the same cycle, because both pins are combinational from those registers. A table of enable/steering/event combinations therefore catches a corrupted bit one clock after the stimulus. A held bit that clears too early, or a live bit that fails to clear, is visible on the next status read, which returns the register exactly. Read-clear races are exposed by a second read one clock later.

// File: rtl/sns_irq_pkg.sv
package sns_irq_pkg;
    localparam int EVT_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_EN  = 2'd0,
        REG_MAP = 2'd1,
        REG_SRC = 2'd2,
        REG_RSV = 2'd3
    } reg_sel_e;

    // bits that follow a live condition: data ready, watermark, overrun
    localparam logic [EVT_W-1:0] LEVEL_MASK = 8'b1000_0011;
    localparam logic [EVT_W-1:0] LATCH_MASK = ~LEVEL_MASK;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import sns_irq_pkg::*;
#(
    parameter int N = EVT_W,
    parameter logic [N-1:0] LVL = LEVEL_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] src
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            if (LVL[i]) begin : g_level
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) src[i] <= 1'b0;
                    else        src[i] <= evt[i];
                end
            end else begin : g_hold
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) src[i] <= 1'b0;
                    else        src[i] <= evt[i] | (src[i] & ~clr);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import sns_irq_pkg::*;
#(
    parameter int N = EVT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  src,
    output logic [N-1:0]  rdata,
    output logic [N-1:0]  en,
    output logic [N-1:0]  map,
    output logic          src_clr
);
    reg_sel_e     sel;
    logic [N-1:0] rd_mux;

    assign sel     = reg_sel_e'(addr);
    assign src_clr = rd && (sel == REG_SRC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= '0;
            map <= '0;
        end else if (wr) begin
            if (sel == REG_EN)  en  <= wdata;
            if (sel == REG_MAP) map <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            REG_EN:  rd_mux = en;
            REG_MAP: rd_mux = map;
            REG_SRC: rd_mux = src;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end
endmodule

// File: rtl/irq_pin_route.sv
module irq_pin_route
    import sns_irq_pkg::*;
#(
    parameter int N = EVT_W,
    parameter int PINS = 2
) (
    input  logic [N-1:0]    src,
    input  logic [N-1:0]    en,
    input  logic [N-1:0]    map,
    output logic [PINS-1:0] pin
);
    logic [N-1:0] armed;
    assign armed = src & en;

    genvar p;
    generate
        for (p = 0; p < PINS; p++) begin : g_pin
            logic [N-1:0] steer;
            assign steer  = (p == 0) ? ~map : map;
            assign pin[p] = |(armed & steer);
        end
    endgenerate
endmodule

// File: rtl/sns_irq_ctrl.sv
module sns_irq_ctrl
    import sns_irq_pkg::*;
#(
    parameter int N  = EVT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_in,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    output logic          irq_pin1,
    output logic          irq_pin2
);
    logic [N-1:0] src_q;
    logic [N-1:0] en_q;
    logic [N-1:0] map_q;
    logic         clr;
    logic [1:0]   pins;

    irq_cfg_regs #(.N(N), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .src(src_q), .rdata(bus_rdata),
        .en(en_q), .map(map_q), .src_clr(clr)
    );

    irq_src_bank #(.N(N), .LVL(LEVEL_MASK)) u_src (
        .clk(clk), .rst_n(rst_n), .evt(evt_in), .clr(clr), .src(src_q)
    );

    irq_pin_route #(.N(N), .PINS(2)) u_route (
        .src(src_q), .en(en_q), .map(map_q), .pin(pins)
    );

    assign irq_pin1 = pins[0];
    assign irq_pin2 = pins[1];
endmodule

// File: rtl/sns_irq_chk.sv
module sns_irq_chk
    import sns_irq_pkg::*;
#(
    parameter int N  = EVT_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  evt_in,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [N-1:0]  src,
    input logic [N-1:0]  en,
    input logic [N-1:0]  map,
    input logic          irq_pin1,
    input logic          irq_pin2
);
    logic src_rd;
    assign src_rd = bus_rd && (bus_addr == REG_SRC);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_chk
            if (!LEVEL_MASK[i]) begin : g_hold
                assert_pulse_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    evt_in[i] |=> src[i]);
                assert_bit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    (src[i] && !src_rd) |=> src[i]);
            end
        end
    endgenerate

    assert_level_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src & LEVEL_MASK) == ($past(evt_in) & LEVEL_MASK)));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd && ((evt_in & LATCH_MASK) == '0)) |=> ((src & LATCH_MASK) == '0));

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (!irq_pin1 && !irq_pin2));

    assert_map_steers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((map == '0) |-> !irq_pin2) and ((map == '1) |-> !irq_pin1));

    assert_cfg_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && (bus_addr == REG_EN || bus_addr == REG_MAP))) |=> ($stable(en) && $stable(map)));
endmodule

bind sns_irq_ctrl sns_irq_chk #(.N(N), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .src(src_q), .en(en_q), .map(map_q),
    .irq_pin1(irq_pin1), .irq_pin2(irq_pin2)
);

// File: tb/sim_sns_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sns_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_in = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_pin1, irq_pin2;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sns_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pin1(irq_pin1), .irq_pin2(irq_pin2)
    );

    // {enable, steering, events, pin1, pin2}
    localparam logic [25:0] VEC [10] = '{
        {8'hFF, 8'h00, 8'h80, 1'b1, 1'b0},
        {8'hFF, 8'hFF, 8'h80, 1'b0, 1'b1},
        {8'h00, 8'h00, 8'hFF, 1'b0, 1'b0},
        {8'h40, 8'h40, 8'h40, 1'b0, 1'b1},
        {8'h40, 8'h00, 8'h20, 1'b0, 1'b0},
        {8'h03, 8'h01, 8'h01, 1'b0, 1'b1},
        {8'h03, 8'h01, 8'h02, 1'b1, 1'b0},
        {8'h3C, 8'h0C, 8'h0C, 1'b0, 1'b1},
        {8'h3C, 8'h0C, 8'h30, 1'b1, 1'b0},
        {8'hFF, 8'h0F, 8'h81, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        logic [7:0] r;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 pins", {6'd0, irq_pin2, irq_pin1}, 8'h00);
        rst_n = 1'b1;
        tick();
        rd_reg(2'd0, r); check("R1 enable", r, 8'h00);
        rd_reg(2'd1, r); check("R1 steering", r, 8'h00);
        rd_reg(2'd2, r); check("R1 status", r, 8'h00);

        // R6 table walk
        for (int k = 0; k < 10; k++) begin
            logic [7:0] ve, vm, vv;
            {ve, vm, vv} = VEC[k][25:2];
            evt_in = '0;
            tick();
            rd_reg(2'd2, r);
            wr_reg(2'd0, ve);
            wr_reg(2'd1, vm);
            evt_in = vv;
            tick();
            check($sformatf("R6 pins vec%0d", k), {6'd0, irq_pin2, irq_pin1}, {6'd0, VEC[k][0], VEC[k][1]});
            rd_reg(2'd2, r);
            check($sformatf("R2 status vec%0d", k), r, vv);
            evt_in = '0;
        end
        tick();
        rd_reg(2'd2, r);

        // R2 and R7: hold while disabled, poll
        wr_reg(2'd0, 8'h00);
        evt_in = 8'h40; tick(); evt_in = '0;
        tick(); tick(); tick();
        check("R7 pins disabled", {6'd0, irq_pin2, irq_pin1}, 8'h00);
        rd_reg(2'd2, r); check("R2 held single tap", r, 8'h40);
        rd_reg(2'd2, r); check("R3 cleared after read", r, 8'h00);

        // R7: enable then disable
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'hFF);
        evt_in = 8'h04; tick(); evt_in = '0;
        check("R6 free fall pin1", {6'd0, irq_pin2, irq_pin1}, 8'h01);
        wr_reg(2'd0, 8'h00);
        check("R7 pin drops on disable", {6'd0, irq_pin2, irq_pin1}, 8'h00);
        rd_reg(2'd2, r); check("R7 status still polled", r, 8'h04);

        // R4 and R3: level bits unaffected by read
        evt_in = 8'h82; tick();
        rd_reg(2'd2, r); check("R4 level set", r, 8'h82);
        rd_reg(2'd2, r); check("R3 level survives read", r, 8'h82);
        evt_in = 8'h00; tick();
        rd_reg(2'd2, r); check("R4 level drops", r, 8'h00);

        // R5: pulse coincident with status read
        evt_in = 8'h10; tick();
        bus_addr = 2'd2; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0; evt_in = '0;
        check("R5 read value", bus_rdata, 8'h10);
        rd_reg(2'd2, r); check("R5 event wins over clear", r, 8'h10);
        rd_reg(2'd2, r); check("R5 clears next read", r, 8'h00);

        // R8: readback and ignored writes
        wr_reg(2'd0, 8'h5A);
        wr_reg(2'd1, 8'hA5);
        rd_reg(2'd0, r); check("R8 enable readback", r, 8'h5A);
        rd_reg(2'd1, r); check("R8 steering readback", r, 8'hA5);
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd2, r); check("R8 status not writable", r, 8'h00);
        rd_reg(2'd3, r); check("R8 unused reads zero", r, 8'h00);
        rd_reg(2'd0, r); check("R8 enable unchanged", r, 8'h5A);
        rd_reg(2'd1, r); check("R8 steering unchanged", r, 8'hA5);

        report();
    end
endmodule